// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns audio samples into a two-channel serial stream and drives the bit clock and the channel-select line itself, so it acts as the clock master of the link. Software or a data mover writes one 32-bit word per channel into a single holding register, left channel first. The block takes each word from that register at the start of the matching slot and shifts it out MSB first. Its transmit-ready output is high whenever the register is empty and can take the next word.

A set of configuration inputs chooses the sample length, the slot width, the framing (standard I2S or left-justified), mono duplication and what is sent when a slot begins with no word waiting. The block copies these inputs into a configuration register when it is enabled, so they can be set up in any order beforehand. Three single-cycle command inputs start the transmitter, stop it, and return it to its reset state. A loop control steers the serial output onto the receive-side data feed in place of the external receive pin.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The length code `cfg_len` selects the sample width: 0 gives 32 bits, 1 gives 24, 2 gives 20, 3 gives 18, 4 and 5 give 16, 6 and 7 give 8. The sample is the low bits of the written word. It is sent MSB first, and any slot bits after its LSB are 0.
- R2: The slot is 32 bits for 32-bit samples, 16 for 16-bit samples and 8 for 8-bit samples. For 18-, 20- and 24-bit samples it is 32 bits when `cfg_slot24` is 0 and 24 bits when it is 1. One frame is a left slot followed by a right slot.
- R3: With `cfg_lj` = 0 (I2S framing), `ws` is low for the left slot and high for the right slot. It changes on a falling `bclk` edge, and each slot's MSB appears one bit clock after the `ws` change.
- R4: With `cfg_lj` = 1 (left-justified), `ws` is high for the left slot, and each slot's MSB appears on the same falling edge as the `ws` change.
- R5: While enabled, `bclk` toggles every HALF_DIV clock cycles. Its first rise comes HALF_DIV cycles after the enable edge. `ws` and `sdata` change only when `bclk` falls, and `bclk` stays low while the transmitter is disabled.
- R6: `tx_ready` is high while the holding register is empty. A write (`hold_wr`) is accepted only when `tx_ready` is high, and `tx_ready` drops in the next cycle. The register is emptied at the falling `bclk` edge that starts a slot.
- R7: With `cfg_mono` = 1, the right slot repeats the sample sent in the left slot of the same frame, and only one word is taken per frame.
- R8: When a slot that needs a new word starts and the register is empty, `tx_underrun` pulses for one cycle. The slot then carries zero if `cfg_fill_repeat` is 0, or the last word taken for that channel if it is 1.
- R9: A `cmd_tx_on` pulse while disabled enables the block and captures the configuration; configuration changes and further `cmd_tx_on` pulses while enabled have no effect. A `cmd_tx_off` pulse drives `bclk`, `ws` and `sdata` low at the next edge, and it keeps a word already waiting in the holding register. The stored previous samples are cleared on each enable.
- R10: A `cmd_soft_rst` pulse (priority over `cmd_tx_off`, which has priority over `cmd_tx_on`) disables the block, empties the holding register and clears the configuration and previous samples.
- R11: `rx_feed` equals `sdata` while `loop_en` is 1 and `rx_pin` otherwise.
- R12: After reset, `tx_ready` is 1 and `bclk`, `ws`, `sdata` and `tx_underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_tx_on | input | 1 | Enable pulse |
| cmd_tx_off | input | 1 | Disable pulse |
| cmd_soft_rst | input | 1 | Return-to-idle pulse |
| cfg_len | input | 3 | Sample length code |
| cfg_slot24 | input | 1 | 24-bit slot for 18/20/24-bit samples |
| cfg_lj | input | 1 | 0 = I2S framing, 1 = left-justified |
| cfg_mono | input | 1 | Duplicate left sample into right slot |
| cfg_fill_repeat | input | 1 | Underrun fill: 0 zero, 1 previous sample |
| loop_en | input | 1 | Route serial output to rx_feed |
| hold_wr | input | 1 | Holding register write strobe |
| hold_wdata | input | 32 | Word to transmit |
| rx_pin | input | 1 | External receive data |
| tx_ready | output | 1 | Holding register empty |
| tx_underrun | output | 1 | One-cycle pulse: slot started without a word |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Channel select |
| sdata | output | 1 | Serial data |
| rx_feed | output | 1 | Data toward the receiver |

## Verification
`bclk`, `ws`, `sdata` and `tx_underrun` come from registers that update on the same system-clock edge, at the edge where `bclk` falls. `tx_ready` drops one cycle after an accepted write and rises at the slot-start edge. After a stop or reset command, the outputs go quiet on the very next edge. The bench keeps a behavioural model that steps once per rising edge using the same input values the design sees. It compares every output at the following falling edge, so each result is checked in the cycle it is due. Inputs change only a short delay after that comparison.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  typedef struct packed {
    logic [2:0] len_code;
    logic       slot24;
    logic       lj;
    logic       mono;
    logic       fill_repeat;
  } tx_cfg_t;

  // sample length in bits for a length code
  function automatic logic [LEN_W-1:0] sample_bits(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd0:       n = 6'd32;
      3'd1:       n = 6'd24;
      3'd2:       n = 6'd20;
      3'd3:       n = 6'd18;
      3'd4, 3'd5: n = 6'd16;
      default:    n = 6'd8;
    endcase
    return n;
  endfunction

  // slot length in bits; only mid-size samples honour the 24-bit slot option
  function automatic logic [LEN_W-1:0] slot_bits(input logic [2:0] code,
                                                 input logic       slot24);
    logic [LEN_W-1:0] n;
    n = sample_bits(code);
    if (n > 6'd16 && n < 6'd32) begin
      n = slot24 ? 6'd24 : 6'd32;
    end
    return n;
  endfunction

endpackage

// File: rtl/i2stx_bitclk.sv
module i2stx_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic halt,
  output logic bclk,
  output logic fall
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = !halt && (cnt == LAST);
  assign fall = tick && bclk;

  always_ff @(posedge clk) begin
    if (halt) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        bclk <= ~bclk;
      end
    end
  end
endmodule

// File: rtl/i2stx_holdreg.sv
module i2stx_holdreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (clr) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr && !full) begin
      full <= 1'b1;
      data <= wdata;
    end
  end
endmodule

// File: rtl/i2stx_picker.sv
module i2stx_picker
  import i2stx_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              start_l,
  input  logic              start_r,
  input  logic              mono,
  input  logic              fill_repeat,
  input  logic [LEN_W-1:0]  len,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  output logic              take,
  output logic              ur_now,
  output logic [WORD_W-1:0] aligned
);
  logic [WORD_W-1:0] fresh;
  logic [WORD_W-1:0] prev_l;
  logic [WORD_W-1:0] prev_r;
  logic [WORD_W-1:0] sent_l;
  logic [LEN_W-1:0]  lshift;

  // MSB-align the low 'len' bits; the shift drops the unused upper bits
  assign lshift = 6'd32 - len;
  assign fresh  = hold_data << lshift;

  always_comb begin
    take    = 1'b0;
    ur_now  = 1'b0;
    aligned = '0;
    if (start_l) begin
      if (hold_full) begin
        take    = 1'b1;
        aligned = fresh;
      end else begin
        ur_now  = 1'b1;
        aligned = fill_repeat ? prev_l : '0;
      end
    end else if (start_r) begin
      if (mono) begin
        aligned = sent_l;
      end else if (hold_full) begin
        take    = 1'b1;
        aligned = fresh;
      end else begin
        ur_now  = 1'b1;
        aligned = fill_repeat ? prev_r : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      prev_l <= '0;
      prev_r <= '0;
      sent_l <= '0;
    end else begin
      if (start_l) begin
        sent_l <= aligned;
      end
      if (take && start_l) begin
        prev_l <= fresh;
      end
      if (take && start_r) begin
        prev_r <= fresh;
      end
    end
  end
endmodule

// File: rtl/i2stx_framer.sv
module i2stx_framer
  import i2stx_pkg::*;
(
  input  logic              clk,
  input  logic              halt,
  input  logic              fall,
  input  logic              lj,
  input  logic [LEN_W-1:0]  slot,
  input  logic [WORD_W-1:0] aligned,
  output logic              start_l,
  output logic              start_r,
  output logic              ws,
  output logic              sdata
);
  localparam int POS_W = LEN_W + 1;

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  pos_n;
  logic [POS_W-1:0]  dpos;
  logic [POS_W-1:0]  span;
  logic [POS_W-1:0]  slot_x;
  logic              started;
  logic [WORD_W-1:0] sh;

  assign slot_x = {1'b0, slot};
  assign span   = {slot, 1'b0};

  always_comb begin
    if (!started) begin
      pos_n = '0;
    end else if (pos == span - 1'b1) begin
      pos_n = '0;
    end else begin
      pos_n = pos + 1'b1;
    end
    // data index trails the frame position by one bit in I2S framing
    if (lj) begin
      dpos = pos_n;
    end else if (pos_n == '0) begin
      dpos = span - 1'b1;
    end else begin
      dpos = pos_n - 1'b1;
    end
  end

  assign start_l = fall && (dpos == '0);
  assign start_r = fall && (dpos == slot_x);

  always_ff @(posedge clk) begin
    if (halt) begin
      pos     <= '0;
      started <= 1'b0;
      ws      <= 1'b0;
      sdata   <= 1'b0;
      sh      <= '0;
    end else if (fall) begin
      pos     <= pos_n;
      started <= 1'b1;
      ws      <= lj ? (pos_n < slot_x) : (pos_n >= slot_x);
      if (start_l || start_r) begin
        sdata <= aligned[WORD_W-1];
        sh    <= aligned << 1;
      end else begin
        sdata <= sh[WORD_W-1];
        sh    <= sh << 1;
      end
    end
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2stx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_tx_on,
  input  logic        cmd_tx_off,
  input  logic        cmd_soft_rst,
  input  logic [2:0]  cfg_len,
  input  logic        cfg_slot24,
  input  logic        cfg_lj,
  input  logic        cfg_mono,
  input  logic        cfg_fill_repeat,
  input  logic        loop_en,
  input  logic        hold_wr,
  input  logic [31:0] hold_wdata,
  input  logic        rx_pin,
  output logic        tx_ready,
  output logic        tx_underrun,
  output logic        bclk,
  output logic        ws,
  output logic        sdata,
  output logic        rx_feed
);
  logic              en;
  tx_cfg_t           cfg;
  logic              kill;
  logic              halt;
  logic              start_cmd;
  logic              fall;
  logic              start_l;
  logic              start_r;
  logic              take;
  logic              ur_now;
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic [WORD_W-1:0] aligned;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  slot;

  assign kill      = rst || cmd_soft_rst;
  assign halt      = kill || cmd_tx_off || !en;
  assign start_cmd = cmd_tx_on && !en && !cmd_tx_off && !cmd_soft_rst;
  assign len       = sample_bits(cfg.len_code);
  assign slot      = slot_bits(cfg.len_code, cfg.slot24);

  always_ff @(posedge clk) begin
    if (kill) begin
      en  <= 1'b0;
      cfg <= '0;
    end else if (cmd_tx_off) begin
      en <= 1'b0;
    end else if (start_cmd) begin
      en  <= 1'b1;
      cfg <= '{len_code: cfg_len, slot24: cfg_slot24, lj: cfg_lj,
               mono: cfg_mono, fill_repeat: cfg_fill_repeat};
    end
  end

  i2stx_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
    .clk  (clk),
    .halt (halt),
    .bclk (bclk),
    .fall (fall)
  );

  i2stx_holdreg #(.W(WORD_W)) u_hold (
    .clk   (clk),
    .clr   (kill),
    .wr    (hold_wr),
    .wdata (hold_wdata),
    .take  (take),
    .full  (hold_full),
    .data  (hold_data)
  );

  i2stx_picker u_pick (
    .clk         (clk),
    .clr         (kill || start_cmd),
    .start_l     (start_l),
    .start_r     (start_r),
    .mono        (cfg.mono),
    .fill_repeat (cfg.fill_repeat),
    .len         (len),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .take        (take),
    .ur_now      (ur_now),
    .aligned     (aligned)
  );

  i2stx_framer u_frame (
    .clk     (clk),
    .halt    (halt),
    .fall    (fall),
    .lj      (cfg.lj),
    .slot    (slot),
    .aligned (aligned),
    .start_l (start_l),
    .start_r (start_r),
    .ws      (ws),
    .sdata   (sdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= ur_now;
    end
  end

  assign tx_ready = !hold_full;
  assign rx_feed  = loop_en ? sdata : rx_pin;
endmodule

// File: rtl/i2stx_checker.sv
module i2stx_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic cmd_tx_off,
  input logic cmd_soft_rst,
  input logic hold_wr,
  input logic tx_ready,
  input logic tx_underrun,
  input logic bclk,
  input logic ws,
  input logic sdata
);
  assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(ws)) |-> $fell(bclk));

  assert_data_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(sdata)) |-> $fell(bclk));

  assert_idle_clock_R5: assert property (@(posedge clk) disable iff (rst)
    !en |-> !bclk);

  assert_ready_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_wr && tx_ready && !cmd_soft_rst) |=> !tx_ready);

  assert_underrun_slot_R8: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> $fell(bclk));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_tx_off || cmd_soft_rst) |=> (!bclk && !ws && !sdata));

  assert_srst_empty_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_soft_rst |=> tx_ready);
endmodule

bind i2s_tx_serializer i2stx_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .cmd_tx_off   (cmd_tx_off),
  .cmd_soft_rst (cmd_soft_rst),
  .hold_wr      (hold_wr),
  .tx_ready     (tx_ready),
  .tx_underrun  (tx_underrun),
  .bclk         (bclk),
  .ws           (ws),
  .sdata        (sdata)
);

// File: tb/tb_i2s_tx_serializer.sv
module tb_i2s_tx_serializer;
  localparam int CLK_P = 10;
  localparam int HD    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_tx_on = 1'b0, cmd_tx_off = 1'b0, cmd_soft_rst = 1'b0;
  logic [2:0]  cfg_len = 3'd0;
  logic        cfg_slot24 = 1'b0, cfg_lj = 1'b0, cfg_mono = 1'b0, cfg_fill_repeat = 1'b0;
  logic        loop_en = 1'b0, hold_wr = 1'b0, rx_pin = 1'b0;
  logic [31:0] hold_wdata = 32'd0;
  logic        tx_ready, tx_underrun, bclk, ws, sdata, rx_feed;

  always #(CLK_P/2) clk = ~clk;

  i2s_tx_serializer #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst(rst), .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off),
    .cmd_soft_rst(cmd_soft_rst), .cfg_len(cfg_len), .cfg_slot24(cfg_slot24),
    .cfg_lj(cfg_lj), .cfg_mono(cfg_mono), .cfg_fill_repeat(cfg_fill_repeat),
    .loop_en(loop_en), .hold_wr(hold_wr), .hold_wdata(hold_wdata), .rx_pin(rx_pin),
    .tx_ready(tx_ready), .tx_underrun(tx_underrun), .bclk(bclk), .ws(ws),
    .sdata(sdata), .rx_feed(rx_feed)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string ph = "R12";

  task automatic chk_eq(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int len_of(input int code);
    int t[8] = '{32, 24, 20, 18, 16, 16, 8, 8};
    return t[code];
  endfunction

  function automatic int slot_of(input int code, input int s24);
    int n = len_of(code);
    if (n == 32 || n <= 16) return n;
    return (s24 != 0) ? 24 : 32;
  endfunction

  // ---------------- behavioural reference model ----------------
  int        m_en = 0, m_cnt = 0, m_bclk = 0, m_started = 0, m_pos = 0;
  int        m_ws = 0, m_sd = 0, m_full = 0, m_ur = 0;
  int        mL = 32, mSW = 32, mlj = 0, mmono = 0, mrep = 0;
  bit [31:0] m_hold = 0, m_sentl = 0;
  bit [31:0] m_cur [2];
  bit [31:0] m_prev [2];
  int        fall_now, took, span, d, sl, k;
  bit [31:0] smp;

  initial begin
    m_cur[0] = 0; m_cur[1] = 0; m_prev[0] = 0; m_prev[1] = 0;
  end

  always @(posedge clk) begin
    fall_now = 0;
    took = 0;
    m_ur = 0;
    if (m_en != 0 && !rst && !cmd_soft_rst && !cmd_tx_off) begin
      if (m_cnt == HD - 1) begin
        fall_now = m_bclk;
        m_bclk = 1 - m_bclk;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end else begin
      m_cnt = 0; m_bclk = 0; m_started = 0; m_pos = 0; m_ws = 0; m_sd = 0;
      m_cur[0] = 0; m_cur[1] = 0;
    end
    if (fall_now != 0) begin
      span = 2 * mSW;
      m_pos = (m_started != 0) ? (m_pos + 1) % span : 0;
      m_started = 1;
      d  = (mlj != 0) ? m_pos : (m_pos + span - 1) % span;
      sl = (d >= mSW) ? 1 : 0;
      k  = d % mSW;
      if (k == 0) begin
        if (sl == 1 && mmono != 0) begin
          smp = m_sentl;
        end else if (m_full != 0) begin
          smp = m_hold << (32 - mL);
          m_prev[sl] = smp;
          m_full = 0;
          took = 1;
        end else begin
          m_ur = 1;
          smp = (mrep != 0) ? m_prev[sl] : 32'd0;
        end
        if (sl == 0) m_sentl = smp;
        m_cur[sl] = smp;
      end
      m_sd = (k < mL) ? int'(m_cur[sl][31-k]) : 0;
      m_ws = (mlj != 0) ? int'(m_pos < mSW) : int'(m_pos >= mSW);
    end
    if (rst || cmd_soft_rst) begin
      m_full = 0; m_hold = 0;
    end else if (took == 0 && hold_wr && m_full == 0) begin
      m_full = 1; m_hold = hold_wdata;
    end
    if (rst || cmd_soft_rst) begin
      m_en = 0; mL = 32; mSW = 32; mlj = 0; mmono = 0; mrep = 0;
      m_prev[0] = 0; m_prev[1] = 0; m_sentl = 0;
    end else if (cmd_tx_off) begin
      m_en = 0;
    end else if (cmd_tx_on && m_en == 0) begin
      m_en = 1;
      mL = len_of(int'(cfg_len));
      mSW = slot_of(int'(cfg_len), int'(cfg_slot24));
      mlj = int'(cfg_lj); mmono = int'(cfg_mono); mrep = int'(cfg_fill_repeat);
      m_prev[0] = 0; m_prev[1] = 0; m_sentl = 0;
    end
  end

  // ---------------- per-cycle comparison and measurements ----------------
  int ur_seen = 0;
  int bclk_q = 0, ws_q = 0;
  int last_bclk_rise = 0, bclk_per = 0, last_ws_rise = 0, ws_per = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 1) begin
      chk_eq("R5", "bclk", bclk, m_bclk);
      chk_eq(ph, "ws", ws, m_ws);
      chk_eq(ph, "sdata", sdata, m_sd);
      chk_eq("R6", "tx_ready", tx_ready, (m_full == 0) ? 1 : 0);
      chk_eq("R8", "tx_underrun", tx_underrun, m_ur);
      chk_eq("R11", "rx_feed", rx_feed, loop_en ? m_sd : int'(rx_pin));
    end
    if (tx_underrun) ur_seen++;
    if (bclk && bclk_q == 0) begin
      if (last_bclk_rise > 0) bclk_per = cyc - last_bclk_rise;
      last_bclk_rise = cyc;
    end
    bclk_q = int'(bclk);
    if (ws && ws_q == 0) begin
      if (last_ws_rise > 0) ws_per = cyc - last_ws_rise;
      last_ws_rise = cyc;
    end
    ws_q = int'(ws);
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- sample feeder ----------------
  int feed_left = 0;
  int feed_idx = 0;

  always @(negedge clk) begin
    #1;
    if (feed_left > 0 && tx_ready) begin
      hold_wr    = 1'b1;
      hold_wdata = 32'hC3A5_5A3C ^ (32'(feed_idx) * 32'h0913_7F2B);
      feed_idx++;
      feed_left--;
    end else begin
      hold_wr = 1'b0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_on();
    cmd_tx_on = 1'b1; step(1); cmd_tx_on = 1'b0;
  endtask

  task automatic pulse_off();
    cmd_tx_off = 1'b1; step(1); cmd_tx_off = 1'b0;
  endtask

  task automatic pulse_srst();
    cmd_soft_rst = 1'b1; step(1); cmd_soft_rst = 1'b0;
  endtask

  task automatic setup(input int code, input bit s24, input bit lj, input bit mono,
                       input bit rep, input string tag);
    ph = tag;
    cfg_len = 3'(code); cfg_slot24 = s24; cfg_lj = lj;
    cfg_mono = mono; cfg_fill_repeat = rep;
  endtask

  task automatic run_phase(input int nfeed, input int ncyc);
    feed_left = nfeed;
    step(12);
    pulse_on();
    step(ncyc);
    feed_left = 0;
    pulse_off();
    step(4);
  endtask

  int ur_before;

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R12: reset state
    chk_eq("R12", "tx_ready after reset", tx_ready, 1);
    chk_eq("R12", "bclk after reset", bclk, 0);
    chk_eq("R12", "ws after reset", ws, 0);
    chk_eq("R12", "sdata after reset", sdata, 0);
    chk_eq("R12", "tx_underrun after reset", tx_underrun, 0);

    // R1: 24-bit samples in 32-bit slots, I2S framing
    setup(1, 0, 0, 0, 0, "R1");
    run_phase(6, 800);
    chk_eq("R5", "bclk period", bclk_per, 2 * HD);

    // R3: 16-bit I2S framing, frame of 32 bits
    setup(4, 0, 0, 0, 0, "R3");
    run_phase(6, 420);
    chk_eq("R3", "ws period 16-bit slots", ws_per, 2 * 16 * 2 * HD);

    // R4: 32-bit left-justified
    setup(0, 0, 1, 0, 0, "R4");
    run_phase(4, 600);
    chk_eq("R4", "ws period 32-bit slots", ws_per, 2 * 32 * 2 * HD);

    // R7: 8-bit mono, left-justified, zero fill once words run out
    setup(6, 0, 1, 1, 0, "R7");
    run_phase(4, 360);
    chk_eq("R7", "ws period 8-bit slots", ws_per, 2 * 8 * 2 * HD);

    // R2: 18-bit samples in 24-bit slots, repeat fill
    setup(3, 1, 0, 0, 1, "R2");
    ur_before = ur_seen;
    run_phase(3, 700);
    chk_eq("R2", "ws period 24-bit slots", ws_per, 2 * 24 * 2 * HD);
    chk_eq("R8", "underrun seen with repeat fill", int'(ur_seen > ur_before), 1);

    // R8: 20-bit samples, 32-bit slot, zero fill, starved
    setup(2, 0, 0, 0, 0, "R8");
    ur_before = ur_seen;
    run_phase(1, 600);
    chk_eq("R8", "underrun seen with zero fill", int'(ur_seen > ur_before), 1);

    // R9: configuration frozen while running, stop behaviour
    setup(4, 0, 0, 0, 0, "R9");
    feed_left = 40;
    step(12);
    pulse_on();
    step(100);
    cfg_len = 3'd0; cfg_lj = 1'b1; cfg_mono = 1'b1; cfg_slot24 = 1'b1;
    step(150);
    pulse_on();
    step(150);
    chk_eq("R9", "ws period unchanged by new settings", ws_per, 2 * 16 * 2 * HD);
    feed_left = 0;
    pulse_off();
    chk_eq("R9", "bclk low after stop", bclk, 0);
    chk_eq("R9", "ws low after stop", ws, 0);
    chk_eq("R9", "sdata low after stop", sdata, 0);
    step(2);
    feed_left = 1;
    step(4);
    chk_eq("R9", "word kept while disabled", tx_ready, 0);
    step(20);
    chk_eq("R9", "word still kept", tx_ready, 0);

    // R10: soft reset empties the holding register
    ph = "R10";
    pulse_srst();
    chk_eq("R10", "tx_ready after soft reset", tx_ready, 1);
    chk_eq("R10", "bclk after soft reset", bclk, 0);

    // R11: loopback
    setup(4, 0, 0, 0, 1, "R11");
    loop_en = 1'b1;
    feed_left = 6;
    step(12);
    pulse_on();
    for (int i = 0; i < 30; i++) begin
      rx_pin = ~rx_pin;
      step(7);
    end
    loop_en = 1'b0;
    rx_pin = 1'b1;
    step(2);
    chk_eq("R11", "rx_feed follows pin", rx_feed, 1);
    rx_pin = 1'b0;
    step(2);
    chk_eq("R11", "rx_feed follows pin low", rx_feed, 0);
    feed_left = 0;
    pulse_off();
    step(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule